// File: doc/BRIEF.md
# Late-write synchronous SRAM with byte lanes

This block is a cycle-accurate, synthesizable model of a single-port synchronous SRAM with late-write timing. Address and control are captured on a rising clock edge. A read presents its data in the cycle that follows. A write takes its data from the data input one cycle after the command, not in the command cycle. Between the command edge and the data edge the write is held in a pending register. A read that reaches the same address at the edge where that pending write commits gets the new bytes merged with the old ones.

The data bus is split into an input and an output, with an output-valid flag that stands in for a tri-state driver. The other inputs are an active-low chip select, a write strobe, one active-low write enable per 9-bit byte lane, an output enable and an asynchronous sleep input.

After reset, an internal counter marks output-impedance calibration as complete once a parameterized number of cycles has passed. Until then, any read is flagged. Once calibration is done, an update strobe may pulse only in cycles in which the output is not driven.

Top module: `lw_sram`

## Requirements
- R1: When an edge samples cs_n=0 and we_n=0, a write is accepted. The data for that write is taken from din at the next rising edge, and is written only into the lanes enabled at the command edge.
- R2: When an edge samples cs_n=0 and we_n=1, a read is accepted. Its word appears on dout in the following cycle, with dout_vld=1, but only while oe_n=0 and sleep=0. In every other case dout_vld=0 and dout is all zeros.
- R3: Lane i covers din/dout bits [9i+8:9i] and is written when lane_we_n[i]=0. A write with every lane_we_n bit at 1 is aborted and leaves memory unchanged.
- R4: When an edge samples cs_n=1, the cycle is a deselect, no command is performed, and dout_vld is 0 in the following cycle.
- R5: While sleep=1, dout_vld is forced to 0 at once, independent of the clock. Edges that sample sleep=1 perform no command, and memory contents are kept.
- R6: cal_ready is 1 once CAL_CYCLES rising edges have occurred after reset release, and then stays 1. A read accepted at an edge where cal_ready is 0 raises early_rd for the following cycle. The read is still performed.
- R7: zq_upd is 1 for one cycle after an accepted write (including an aborted one) or an accepted deselect edge, and only if cal_ready was 1 at that edge. It is never 1 together with dout_vld.
- R8: A read accepted at the edge where a pending write to the same address commits returns that write's enabled lanes from din, with the remaining lanes taken from the array.
- R9: After sleep falls, the first WAKE_CYCLES rising edges perform no command. A write accepted just before sleep rises still takes its data at the next edge and commits it.
- R10: During and right after reset, dout_vld, zq_upd, early_rd and cal_ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Asynchronous sleep request, active high |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command when low, read when high |
| lane_we_n | input | DATA_W/BYTE_W | Per-lane write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data, taken one cycle after the write command |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_vld | output | 1 | Output is being driven |
| cal_ready | output | 1 | Impedance calibration period has elapsed |
| early_rd | output | 1 | A read was issued before calibration completed |
| zq_upd | output | 1 | Impedance update strobe |

## Verification
The properties assume that every input changes well away from the rising edge. They also assume that sleep, although it gates the output at any time, is seen by the command logic only as it is sampled at an edge. The bench changes inputs 2 ns after each edge and samples outputs 6 ns after it, so oe_n and sleep for a given output cycle are the values driven in that same cycle. din is treated as meaningful only in the slot right after a write. The stimulus gives din the data for the previous write in every slot, including slots that sample sleep. This covers the case where a write is caught by sleep entry.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

endpackage

// File: rtl/lw_decode.sv
module lw_decode
    import lw_sram_pkg::*;
(
    input  logic accept,
    input  logic cs_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (!accept) begin
            cmd = CMD_NONE;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else if (!we_n) begin
            cmd = CMD_WRITE;
        end else begin
            cmd = CMD_READ;
        end
    end

endmodule

// File: rtl/lw_cal_timer.sv
module lw_cal_timer #(
    parameter int CAL_CYCLES = 8192
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int CW = $clog2(CAL_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CW'(CAL_CYCLES)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready = (cnt_q == CW'(CAL_CYCLES));

    // R6: once calibration is complete it never drops back
    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/lw_wake_gate.sv
module lw_wake_gate #(
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic awake
);

    localparam int CW = $clog2(WAKE_CYCLES + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sleep) begin
            cnt_d = CW'(WAKE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign awake = !sleep && (cnt_q == '0);

    generate
        if (WAKE_CYCLES > 0) begin : g_wake_chk
            // R9: the edge right after sleep falls must not accept a command
            p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(sleep) |-> !awake);
        end
    endgenerate

endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W/BYTE_W-1:0]   wmask,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata
);

    localparam int LANES = DATA_W / BYTE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              hit;

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we && wmask[i]) begin
                mem_q[waddr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign hit = we && (waddr == raddr);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign rdata[g*BYTE_W +: BYTE_W] = (hit && wmask[g]) ?
                wdata[g*BYTE_W +: BYTE_W] : mem_q[raddr][g*BYTE_W +: BYTE_W];

            // R8: a lane being committed at the read address is seen by the read
            p_fwd_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (we && wmask[g] && (waddr == raddr)) |->
                    (rdata[g*BYTE_W +: BYTE_W] == wdata[g*BYTE_W +: BYTE_W]));
        end
    endgenerate

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int BYTE_W      = 9,
    parameter int ADDR_W      = 6,
    parameter int CAL_CYCLES  = 8192,
    parameter int WAKE_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      cs_n,
    input  logic                      we_n,
    input  logic [DATA_W/BYTE_W-1:0]  lane_we_n,
    input  logic                      oe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         din,
    output logic [DATA_W-1:0]         dout,
    output logic                      dout_vld,
    output logic                      cal_ready,
    output logic                      early_rd,
    output logic                      zq_upd
);

    localparam int LANES = DATA_W / BYTE_W;

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic [LANES-1:0]  pmask;
        logic              rd;
        logic [DATA_W-1:0] rdat;
        logic              early;
        logic              zupd;
    } state_t;

    state_t            st_d, st_q;
    cmd_e              cmd;
    logic              awake;
    logic [DATA_W-1:0] arr_rd;

    lw_wake_gate #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (sleep),
        .awake (awake)
    );

    lw_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (cal_ready)
    );

    lw_decode u_dec (
        .accept (awake),
        .cs_n   (cs_n),
        .we_n   (we_n),
        .cmd    (cmd)
    );

    lw_array #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_q.pend),
        .waddr (st_q.paddr),
        .wmask (st_q.pmask),
        .wdata (din),
        .raddr (addr),
        .rdata (arr_rd)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pend  = (cmd == CMD_WRITE);
        st_d.paddr = addr;
        st_d.pmask = ~lane_we_n;
        st_d.rd    = (cmd == CMD_READ);
        if (cmd == CMD_READ) begin
            st_d.rdat = arr_rd;
        end
        st_d.early = (cmd == CMD_READ) && !cal_ready;
        st_d.zupd  = cal_ready && ((cmd == CMD_WRITE) || (cmd == CMD_DESEL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_vld = st_q.rd && !oe_n && !sleep;
    assign dout     = dout_vld ? st_q.rdat : '0;
    assign early_rd = st_q.early;
    assign zq_upd   = st_q.zupd;

    // R2: the output is only driven in the cycle after an accepted read
    p_drive_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(cmd == CMD_READ));

    // R4: a deselect edge leaves the following cycle undriven
    p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL) |=> !dout_vld);

    // R5: an edge that samples sleep starts neither a read nor a write
    p_sleep_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!st_q.pend && !st_q.rd));

    // R7: update strobe only while the driver is off
    p_upd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zq_upd |-> !dout_vld);

    // R7: update strobe only after calibration
    p_upd_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zq_upd |-> cal_ready);

    // R6: early-read flag can only follow a read
    p_early_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        early_rd |-> $past(cmd == CMD_READ));

endmodule

// File: tb/sim_lw_sram.sv
module sim_lw_sram;

    localparam int DW   = 18;
    localparam int BW   = 9;
    localparam int AW   = 6;
    localparam int NL   = DW / BW;
    localparam int CAL  = 8192;
    localparam int WAKE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [NL-1:0] lane_we_n = '1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld, cal_ready, early_rd, zq_upd;

    always #4 clk = ~clk;

    lw_sram #(.DATA_W(DW), .BYTE_W(BW), .ADDR_W(AW),
              .CAL_CYCLES(CAL), .WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .we_n(we_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dout(dout), .dout_vld(dout_vld), .cal_ready(cal_ready),
        .early_rd(early_rd), .zq_upd(zq_upd)
    );

    typedef struct {
        logic          vld;
        logic [DW-1:0] dat;
        logic          zupd;
        logic          early;
        logic          rdy;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   edges  = 0;

    // reference state
    logic [DW-1:0] ref_mem [1<<AW];
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_paddr = '0;
    logic [NL-1:0] m_pmask = '0;
    logic          p_rd = 1'b0, p_early = 1'b0, p_zupd = 1'b0;
    logic [DW-1:0] p_dat = '0;
    string         p_tag = "R10";
    int            wake = 0;
    logic [DW-1:0] carry = '0;
    string         note = "";

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
        end
    endtask

    // one command slot; din carries the data of the previous slot's write
    task automatic cyc(input logic s_cs, input logic s_we, input logic [NL-1:0] s_lanes,
                       input logic s_oe, input logic s_slp, input logic [AW-1:0] s_addr,
                       input logic [DW-1:0] nd);
        exp_t   e;
        bit     acc, rdy, fwd;
        @(posedge clk);
        #2;
        cs_n = s_cs; we_n = s_we; lane_we_n = s_lanes; oe_n = s_oe;
        sleep = s_slp; addr = s_addr; din = carry;
        e.vld   = p_rd && !s_oe && !s_slp;
        e.dat   = p_dat;
        e.zupd  = p_zupd;
        e.early = p_early;
        e.rdy   = (edges >= CAL);
        e.tag   = s_slp ? "R5 async-off" : (s_oe ? "R2 oe-high" : p_tag);
        q.push_back(e);
        // model the edge that closes this slot
        rdy = (edges >= CAL);
        fwd = m_pend && (m_paddr == s_addr) && (m_pmask != '0);
        if (m_pend) begin
            for (int i = 0; i < NL; i++)
                if (m_pmask[i]) ref_mem[m_paddr][i*BW +: BW] = carry[i*BW +: BW];
        end
        acc = !s_slp && (wake == 0);
        if (s_slp) wake = WAKE;
        else if (wake > 0) wake--;
        m_pend  = acc && !s_cs && !s_we;
        m_paddr = s_addr;
        m_pmask = ~s_lanes;
        p_rd    = acc && !s_cs && s_we;
        if (p_rd) p_dat = ref_mem[s_addr];
        p_early = p_rd && !rdy;
        p_zupd  = rdy && acc && (s_cs || !s_we);
        if (!acc)      p_tag = s_slp ? "R5 ignored" : "R9 wake";
        else if (s_cs) p_tag = "R4 deselect";
        else if (!s_we) p_tag = "R1 write";
        else if (fwd)  p_tag = "R8 forward";
        else           p_tag = "R1 read";
        p_tag = {p_tag, " ", note};
        carry = nd;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] ln, input logic [DW-1:0] d);
        cyc(1'b0, 1'b0, ln, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic oe);
        cyc(1'b0, 1'b1, '1, oe, 1'b0, a, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, '1, 1'b0, 1'b0, '0, '0);
    endtask

    // monitor: compare each cycle's outputs with the queued expectation
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #6;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(dout_vld == e.vld, e.tag, "dout_vld", 32'(dout_vld), 32'(e.vld));
                if (e.vld)
                    chk(dout == e.dat, e.tag, "dout", 32'(dout), 32'(e.dat));
                else
                    chk(dout == '0, {"R2 ", e.tag}, "dout idle", 32'(dout), 32'd0);
                chk(zq_upd == e.zupd, "R7", "zq_upd", 32'(zq_upd), 32'(e.zupd));
                chk(early_rd == e.early, "R6", "early_rd", 32'(early_rd), 32'(e.early));
                chk(cal_ready == e.rdy, "R6", "cal_ready", 32'(cal_ready), 32'(e.rdy));
            end
        end
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #6;
        chk(!dout_vld && !zq_upd && !early_rd && !cal_ready, "R10", "reset outputs",
            {28'd0, dout_vld, zq_upd, early_rd, cal_ready}, 32'd0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // preload every address, then read some before calibration (R6)
        for (int a = 0; a < (1 << AW); a++) wr(AW'(a), '0, DW'(a * 1031 + 7));
        note = "R6 early";
        for (int a = 0; a < 8; a++) rd(AW'(a), 1'b0);
        note = "";
        while (edges < CAL + 2) idle(1);

        // forwarding with partial lanes (R8, R3)
        note = "R3 lane0";
        wr(6'd5, 2'b10, 18'h2A5A5);
        rd(6'd5, 1'b0);
        rd(6'd5, 1'b0);
        note = "R3 lane1";
        wr(6'd12, 2'b01, 18'h1F0F0);
        rd(6'd12, 1'b0);
        idle(1);
        rd(6'd12, 1'b0);
        // aborted write (R3)
        note = "R3 abort";
        wr(6'd6, 2'b11, 18'h3FFFF);
        rd(6'd6, 1'b0);
        idle(2);
        rd(6'd6, 1'b0);
        // output enable high hides the read (R2)
        note = "R2";
        wr(6'd7, 2'b00, 18'h12345);
        rd(6'd7, 1'b1);
        rd(6'd7, 1'b0);
        // back-to-back writes then reads with deselect gaps (R1, R4)
        note = "R1";
        wr(6'd8, 2'b00, 18'h0AAAA);
        wr(6'd9, 2'b00, 18'h15555);
        idle(1);
        rd(6'd8, 1'b0);
        idle(1);
        rd(6'd9, 1'b0);
        rd(6'd8, 1'b0);

        // sleep right after a write: pending data still committed (R9, R5)
        note = "R9 sleep";
        wr(6'd10, 2'b00, 18'h3C3C3);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, '1, 1'b0, 1'b1, 6'd10, '0);
        for (int i = 0; i < WAKE + 3; i++) rd(6'd10, 1'b0);
        // a driven read cut off by sleep mid-cycle (R5)
        note = "R5";
        rd(6'd11, 1'b0);
        cyc(1'b1, 1'b1, '1, 1'b0, 1'b1, '0, '0);
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, 6'd11, 18'h00001);
        for (int i = 0; i < WAKE + 1; i++) idle(1);
        rd(6'd11, 1'b0);
        idle(1);

        // mixed traffic
        note = "mix";
        for (int i = 0; i < 3000; i++) begin
            logic c, w, o, s;
            c = ($urandom % 8) == 0;
            w = $urandom % 2;
            o = ($urandom % 4) == 0;
            s = ($urandom % 40) == 0;
            cyc(c, w, NL'($urandom), o, s, AW'($urandom % 16), DW'($urandom));
        end
        idle(3);

        @(posedge clk);
        #7;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule